// File: doc/BRIEF.md
# Frame-Synchronized Serial Transfer Port

The port moves fixed-length 16-bit words over a one-bit serial line in each direction. Each word starts with a frame synchronization pulse. A small control register sets how the port behaves. It holds two enables (transmit and receive), two interrupt enables and three mode bits. The transmit-sync mode bit chooses where the transmit frame sync comes from. It is either an input from outside, or the port generates it and drives it out on the same pin. The continuity mode bit chooses how often a sync is needed. In continuous mode, one sync starts an unbroken stream of words. In interval mode, every word waits for its own sync.

Parallel data enters and leaves on valid/ready streams, with one word of storage in each direction. On transmit, `tx_ready` is high only while the port is enabled and its single buffer is empty, so the producer holds `tx_valid` and `tx_data` until a transfer edge. On receive, a completed word is held with `rx_valid` high and `rx_data` stable until `rx_ready` is seen high at a clock edge. If a newer word completes before the held word is taken, it replaces the held word. The serial side runs one bit per `clk` cycle. The transmit sync pin is modelled as a driven value plus an output enable.

Top module: `fsync_serial_port`

## Requirements
- R1: After reset, the control register reads 0x0000, `tx_ready`, `rx_valid`, `tx_irq` and `rx_irq` are low, and `tx_sync_oe` is low.
- R2: Read bits 15..7 are always zero, whatever was written.
- R3: The mode bits 6 (transmit-sync source), 5 (continuity) and 4 (spare, no effect on transfers) take a write only if transmit enable (bit 1) and receive enable (bit 0) are both 0 before the write. Otherwise these bits keep their value. Bits 3..0 (transmit interrupt enable, receive interrupt enable, transmit enable, receive enable) always take the write.
- R4: With bit 6 = 1, `tx_sync_oe` is high. A one-cycle `tx_sync_out` pulse is issued when the transmitter is idle with a buffered word, and `tx_sync_in` is ignored. With bit 6 = 0, `tx_sync_oe` and `tx_sync_out` stay low and `tx_sync_in` frames transmit words. The receiver uses only `rx_sync_in`, in both settings.
- R5: A word is sent MSB first on `sd_out`, one bit per cycle. The first bit is driven right after the edge where the sync is taken. The receiver samples `sd_in` on the 16 edges after its sync edge, so `rx_valid` rises 16 cycles after that edge.
- R6: With bit 5 = 1 (interval), every word in each direction needs its own sync. A buffered transmit word without a sync is not sent and stays in the buffer.
- R7: With bit 5 = 0 (continuous), no word moves before the first sync after enable. After it, words follow every 16 cycles and later syncs are ignored. If the buffer is empty at a word boundary, a zero word is sent and received.
- R8: `tx_irq` equals transmit interrupt enable AND `tx_ready`. `rx_irq` equals receive interrupt enable AND `rx_valid`. `rx_valid` and `rx_data` hold while `rx_ready` is low, and `rx_valid` drops after an edge with `rx_ready` high.
- R9: Clearing an enable stops that direction at once and empties its buffer or held word. In continuous mode, a new first sync is then required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write value |
| reg_rdata | output | 16 | Control register read value |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit buffer can take a word |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes the held word |
| rx_data | output | 16 | Received word |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |
| tx_sync_in | input | 1 | External transmit frame sync |
| tx_sync_out | output | 1 | Generated transmit frame sync |
| tx_sync_oe | output | 1 | Drive enable for the transmit sync pin |
| rx_sync_in | input | 1 | Receive frame sync |
| tx_irq | output | 1 | Transmit buffer empty request |
| rx_irq | output | 1 | Received word request |

## Verification
The hardest case to reach from the ports is the word boundary in continuous mode. There, the next buffered word, or a zero word when the buffer is empty, must start on exactly the cycle after the last bit of the previous word, with no sync. The bench connects `sd_out` to `sd_in` and drives both sync pins together. It fires a single sync, then pushes the second word while the first is still shifting, and measures the cycle spacing of the received words. After that it lets the buffer run dry so that the filler word appears.

// File: rtl/fssp_pkg.sv
package fssp_pkg;
  localparam int CTRL_W  = 16;
  localparam int FIELD_W = 7;

  // bit 6 down to bit 0
  typedef struct packed {
    logic tm_int;    // transmit sync generated internally
    logic se_ivl;    // interval mode
    logic spare;     // stored, lock-protected
    logic txie;
    logic rxie;
    logic te;
    logic re;
  } ctrl_t;
endpackage

// File: rtl/fssp_ctrl_reg.sv
module fssp_ctrl_reg
  import fssp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [FIELD_W-1:0]   wfield,
  output logic [CTRL_W-1:0]    rdata,
  output ctrl_t                ctrl
);
  ctrl_t q, nxt;

  always_comb begin
    nxt = q;
    if (we) begin
      nxt = ctrl_t'(wfield);
      if (q.te || q.re) begin
        nxt.tm_int = q.tm_int;
        nxt.se_ivl = q.se_ivl;
        nxt.spare  = q.spare;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign ctrl  = q;
  assign rdata = {{(CTRL_W-FIELD_W){1'b0}}, q};
endmodule

// File: rtl/fssp_tx_path.sv
module fssp_tx_path #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              int_sync,
  input  logic              interval,
  input  logic              ext_sync,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              sd_out,
  output logic              sync_out
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W-1);

  logic [WORD_W-1:0] buf_q, sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic full_q, run_q, locked_q, gen_q;
  logic sync_evt, at_last, slot_free, start, chain, load_buf, load_zero, accept;

  always_comb begin
    sync_evt  = int_sync ? gen_q : ext_sync;
    at_last   = run_q && (cnt_q == LAST);
    slot_free = !run_q || at_last;
    start     = slot_free && !locked_q && sync_evt && full_q;
    chain     = at_last && locked_q;
    load_buf  = start || (chain && full_q);
    load_zero = chain && !full_q;
    in_ready  = en && !full_q;
    accept    = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0; sh_q <= '0; cnt_q <= '0;
      full_q <= 1'b0; run_q <= 1'b0; locked_q <= 1'b0; gen_q <= 1'b0;
    end else if (!en) begin
      full_q <= 1'b0; run_q <= 1'b0; locked_q <= 1'b0; gen_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      gen_q <= int_sync && !run_q && full_q && !gen_q && !locked_q;
      if (accept) begin
        buf_q  <= in_data;
        full_q <= 1'b1;
      end else if (load_buf) begin
        full_q <= 1'b0;
      end
      if (load_buf) begin
        sh_q  <= buf_q;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (load_zero) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (run_q) begin
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q + 1'b1;
        if (at_last) run_q <= 1'b0;
      end
      if (start && !interval) locked_q <= 1'b1;
    end
  end

  assign sd_out   = run_q && sh_q[WORD_W-1];
  assign sync_out = gen_q;
endmodule

// File: rtl/fssp_rx_path.sv
module fssp_rx_path #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              interval,
  input  logic              sync_in,
  input  logic              sd_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W-1);

  logic [WORD_W-1:0] sh_q, hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic run_q, locked_q, valid_q;
  logic at_last, slot_free, start, chain;

  always_comb begin
    at_last   = run_q && (cnt_q == LAST);
    slot_free = !run_q || at_last;
    start     = slot_free && !locked_q && sync_in;
    chain     = at_last && locked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; hold_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; locked_q <= 1'b0; valid_q <= 1'b0;
    end else if (!en) begin
      run_q <= 1'b0; locked_q <= 1'b0; valid_q <= 1'b0; cnt_q <= '0;
    end else begin
      if (run_q) sh_q <= {sh_q[WORD_W-2:0], sd_in};
      if (start || chain) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (at_last) run_q <= 1'b0;
      end
      if (start && !interval) locked_q <= 1'b1;
      if (at_last) begin
        hold_q  <= {sh_q[WORD_W-2:0], sd_in};
        valid_q <= 1'b1;
      end else if (valid_q && out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = hold_q;
endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port
  import fssp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sd_out,
  input  logic              sd_in,
  input  logic              tx_sync_in,
  output logic              tx_sync_out,
  output logic              tx_sync_oe,
  input  logic              rx_sync_in,
  output logic              tx_irq,
  output logic              rx_irq
);
  ctrl_t ctrl;

  fssp_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we),
    .wfield(reg_wdata[FIELD_W-1:0]), .rdata(reg_rdata), .ctrl(ctrl)
  );

  fssp_tx_path #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(ctrl.te), .int_sync(ctrl.tm_int),
    .interval(ctrl.se_ivl), .ext_sync(tx_sync_in),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .sd_out(sd_out), .sync_out(tx_sync_out)
  );

  fssp_rx_path #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(ctrl.re), .interval(ctrl.se_ivl),
    .sync_in(rx_sync_in), .sd_in(sd_in),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  assign tx_sync_oe = ctrl.tm_int;
  assign tx_irq     = ctrl.txie && tx_ready;
  assign rx_irq     = ctrl.rxie && rx_valid;
endmodule

// File: rtl/fssp_checker.sv
module fssp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic       wr_re,
  input logic [2:0] mode_bits,
  input logic [1:0] enables,
  input logic       tx_ready,
  input logic       tx_irq,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_sync_out,
  input logic       tx_sync_oe
);
  // R3
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (enables != 2'b00)) |=> (mode_bits == $past(mode_bits)));

  // R4
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sync_out |=> !tx_sync_out);

  // R4
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_sync_oe |-> !tx_sync_out);

  // R8
  tx_irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_ready);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && enables[0] && !(reg_we && !wr_re)) |=> rx_valid);
endmodule

bind fsync_serial_port fssp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .wr_re(reg_wdata[0]),
  .mode_bits(reg_rdata[6:4]), .enables(reg_rdata[1:0]),
  .tx_ready(tx_ready), .tx_irq(tx_irq), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_sync_out(tx_sync_out), .tx_sync_oe(tx_sync_oe)
);

// File: tb/fsync_serial_port_test.sv
module fsync_serial_port_test;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b1;
  logic [15:0] tx_data = '0, rx_data;
  logic sd_out, tx_sync_out, tx_sync_oe, tx_irq, rx_irq;
  logic tx_sync_drv = 1'b0, rx_sync_drv = 1'b0, loop_int = 1'b0;
  logic rx_sync_in;
  int checks = 0, fails = 0, cyc = 0, sync_cnt = 0, sync_at = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (tx_sync_out) sync_cnt++;

  assign rx_sync_in = loop_int ? tx_sync_out : rx_sync_drv;

  fsync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sd_out(sd_out), .sd_in(sd_out),
    .tx_sync_in(tx_sync_drv), .tx_sync_out(tx_sync_out),
    .tx_sync_oe(tx_sync_oe), .rx_sync_in(rx_sync_in),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = w;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); tx_sync_drv = 1'b1; rx_sync_drv = 1'b1;
    @(negedge clk); tx_sync_drv = 1'b0; rx_sync_drv = 1'b0;
    sync_at = cyc;
  endtask

  task automatic wait_rx(input int limit, output logic got, output logic [15:0] w, output int at);
    got = 1'b0; w = '0; at = 0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1'b1; w = rx_data; at = cyc; end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ctrl", reg_rdata, 16'h0000);
    chk("R1 outputs", {tx_ready, rx_valid, tx_irq, rx_irq, tx_sync_oe}, 5'b0);
  endtask

  task automatic t_reserved();
    wr(16'hFFFF);
    chk("R2 reserved zero", reg_rdata, 16'h007F);
    wr(16'h0000);
    chk("R3 mode kept while enabled", reg_rdata, 16'h0070);
    wr(16'h0000);
    chk("R3 mode cleared when idle", reg_rdata, 16'h0000);
  endtask

  task automatic t_lock();
    wr(16'h0003); wr(16'h0073);
    chk("R3 lock", reg_rdata, 16'h0003);
    wr(16'h000F);
    chk("R3 low bits free", reg_rdata, 16'h000F);
    wr(16'h0000); wr(16'h0070);
    chk("R3 mode write allowed", reg_rdata, 16'h0070);
    wr(16'h0000);
  endtask

  task automatic t_internal_interval();
    logic got; logic [15:0] w; int at;
    loop_int = 1'b1;
    wr(16'h0060); wr(16'h006F);
    chk("R4 oe", tx_sync_oe, 1'b1);
    chk("R8 tx_irq empty", tx_irq, 1'b1);
    sync_cnt = 0;
    push(16'hA5C3);
    wait_rx(60, got, w, at);
    chk("R5 word A", {got, w}, {1'b1, 16'hA5C3});
    chk("R8 rx_irq", rx_irq, 1'b1);
    @(negedge clk);
    chk("R8 rx cleared", {rx_valid, rx_irq}, 2'b00);
    push(16'h1234);
    wait_rx(60, got, w, at);
    chk("R6 word B", {got, w}, {1'b1, 16'h1234});
    chk("R6 one sync per word", sync_cnt, 2);
  endtask

  task automatic t_rx_ignores_tm();
    logic got; logic [15:0] w; int at;
    loop_int = 1'b0;
    push(16'h0F0F);
    wait_rx(60, got, w, at);
    chk("R4 rx needs own sync", got, 1'b0);
    chk("R4 tx sent on internal sync", tx_ready, 1'b1);
    wr(16'h0060); wr(16'h0000);
  endtask

  task automatic t_ext_interval();
    logic got; logic [15:0] w; int at;
    wr(16'h0020); wr(16'h0023);
    chk("R4 ext oe low", tx_sync_oe, 1'b0);
    push(16'h8001);
    wait_rx(40, got, w, at);
    chk("R6 no sync no word", got, 1'b0);
    chk("R6 word kept", tx_ready, 1'b0);
    pulse_sync();
    wait_rx(40, got, w, at);
    chk("R5 word", {got, w}, {1'b1, 16'h8001});
    chk("R5 latency", at - sync_at, 16);
    wr(16'h0020); wr(16'h0000);
  endtask

  task automatic t_ext_continuous();
    logic got; logic [15:0] w; int at, at1;
    wr(16'h0003);
    push(16'hC0DE);
    wait_rx(40, got, w, at);
    chk("R7 waits first sync", got, 1'b0);
    pulse_sync();
    push(16'hBEEF);
    wait_rx(40, got, w, at);
    chk("R7 first word", {got, w}, {1'b1, 16'hC0DE});
    chk("R7 first latency", at - sync_at, 16);
    at1 = at;
    wait_rx(40, got, w, at);
    chk("R7 second word", {got, w}, {1'b1, 16'hBEEF});
    chk("R7 back to back", at - at1, 16);
    at1 = at;
    wait_rx(40, got, w, at);
    chk("R7 underrun zero", {got, w}, {1'b1, 16'h0000});
    chk("R7 underrun spacing", at - at1, 16);
  endtask

  task automatic t_abort();
    logic got; logic [15:0] w; int at;
    wr(16'h0000);
    chk("R9 stopped", {tx_ready, rx_valid}, 2'b00);
    wr(16'h0003);
    push(16'h5555);
    wait_rx(40, got, w, at);
    chk("R9 rearmed", got, 1'b0);
    chk("R9 word held", tx_ready, 1'b0);
    pulse_sync();
    wait_rx(40, got, w, at);
    chk("R9 restart", {got, w}, {1'b1, 16'h5555});
    wr(16'h0000);
  endtask

  task automatic t_backpressure();
    logic got; logic [15:0] w; int at;
    wr(16'h0020); wr(16'h0027);
    rx_ready = 1'b0;
    push(16'h3C3C);
    pulse_sync();
    wait_rx(40, got, w, at);
    repeat (10) @(negedge clk);
    chk("R8 held", {rx_valid, rx_irq, rx_data}, {2'b11, 16'h3C3C});
    rx_ready = 1'b1;
    @(negedge clk);
    chk("R8 released", rx_valid, 1'b0);
    wr(16'h0020); wr(16'h0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reserved();
    t_lock();
    t_internal_interval();
    t_rx_ignores_tm();
    t_ext_interval();
    t_ext_continuous();
    t_abort();
    t_backpressure();
    finish_run();
  end
endmodule